// File: doc/BRIEF.md
# Ternary Match Packet Classifier

This block sorts packets into classes by comparing a 40-bit search key (a 32-bit address followed by an 8-bit protocol code) against a small table of ternary rules, all in parallel. Every rule carries a value word, a care mask and a valid flag. A separate action memory, addressed by rule index, holds the class or verdict for each rule. When several rules match, the one with the lowest index wins. The action stored for that rule is returned with its index. If no valid rule matches, a miss is reported together with a fixed default action.

Software or a control engine loads rules through a single write port. The same port clears a rule's valid flag to take it out of service. The block serves two uses: multi-field filtering, where rules are ordered by importance, and longest-prefix lookup, where longer prefixes are placed at lower indices. A search result appears on the registered outputs one clock after the key is presented.

Top module: `tcam_classifier`

## Requirements
- R1: A key bit whose mask bit is 0 never prevents a match, whatever its value.
- R2: A key bit whose mask bit is 1 matches only when it equals the stored value bit.
- R3: A rule matches only when all 40 bit positions match. A single differing cared-for bit makes it miss.
- R4: When several valid rules match, `res_idx` is the lowest matching index.
- R5: On a hit, `res_action` is the action written for the winning index.
- R6: When no valid rule matches, `res_hit`=0, `res_idx`=0 and `res_action` equals the default action, 8'hFF.
- R7: Reset clears every valid flag. A rule written with `wr_valid`=0 never matches until it is rewritten valid.
- R8: `res_valid` is 1 exactly in the cycle after a cycle with `srch_en`=1, and it is 0 after reset. The result fields belong to that search.
- R9: A write changes only searches presented in later cycles. A search presented in the same cycle as a write sees the table as it was before the write.
- R10: With a /24 prefix at a lower index than a covering /16 prefix, an address inside the /24 returns the /24 rule, and an address outside it but inside the /16 returns the /16 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one rule this cycle |
| wr_idx | input | 4 | Rule index written |
| wr_valid | input | 1 | Valid flag written (0 invalidates) |
| wr_value | input | 40 | Value word written |
| wr_mask | input | 40 | Care mask written (1 = compare bit) |
| wr_action | input | 8 | Action written |
| srch_en | input | 1 | Present a search key this cycle |
| srch_key | input | 40 | Search key: address[39:8], protocol[7:0] |
| res_valid | output | 1 | Result valid (one cycle after `srch_en`) |
| res_hit | output | 1 | Some valid rule matched |
| res_idx | output | 4 | Winning rule index, 0 on miss |
| res_action | output | 8 | Winning action, default on miss |

## Verification
Keys are tried against an exact rule, a prefix-only rule and a protocol-only rule. This separates masked bits that are ignored from cared-for bits that are compared, including a key that differs from a rule in one cared-for bit. Overlapping rules, and a nested /24 and /16 pair, expose priority errors and longest-prefix ordering. An all-wildcard rule written in the same cycle as a search, then invalidated, shows when writes take effect and that invalid rules drop out. Searches against an empty table and idle cycles check the miss default and the one-cycle result strobe.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned TCAM_ENTRIES_DFLT = 16;
  localparam int unsigned TCAM_KEY_W_DFLT   = 40;
  localparam int unsigned TCAM_ACT_W_DFLT   = 8;
  localparam logic [7:0]  TCAM_MISS_ACT     = 8'hFF;
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned KEY_W   = 40,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic [KEY_W-1:0]   wr_value,
  input  logic [KEY_W-1:0]   wr_mask,
  input  logic [KEY_W-1:0]   key,
  output logic [ENTRIES-1:0] match
);
  logic [ENTRIES-1:0] vld;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] msk_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[e] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        vld[e] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(e)) begin
        val_q <= wr_value;
        msk_q <= wr_mask;
      end
    end

    assign match[e] = vld[e] && (((key ^ val_q) & msk_q) == '0);
  end

  assert_reset_clears_R7: assert property (@(posedge clk)
    $past(rst) |-> (match == '0));
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
    any |-> (req[idx] && ((req & ((ENTRIES'(1) << idx) - ENTRIES'(1))) == '0)));
endmodule

// File: rtl/tcam_action_ram.sv
module tcam_action_ram #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ACT_W   = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ACT_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [ACT_W-1:0] rdata
);
  logic [ACT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcam_classifier.sv
module tcam_classifier
  import tcam_pkg::*;
#(
  parameter int unsigned ENTRIES = TCAM_ENTRIES_DFLT,
  parameter int unsigned KEY_W   = TCAM_KEY_W_DFLT,
  parameter int unsigned ACT_W   = TCAM_ACT_W_DFLT,
  parameter logic [ACT_W-1:0] MISS_ACT = ACT_W'(TCAM_MISS_ACT),
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [ACT_W-1:0] wr_action,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx,
  output logic [ACT_W-1:0] res_action
);
  logic [ENTRIES-1:0] match;
  logic               any;
  logic [IDX_W-1:0]   win_idx;
  logic [ACT_W-1:0]   ram_q;

  tcam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_value(wr_value), .wr_mask(wr_mask),
    .key(srch_key), .match(match)
  );

  tcam_prio_enc #(.ENTRIES(ENTRIES)) u_enc (
    .clk(clk), .rst(rst), .req(match), .any(any), .idx(win_idx)
  );

  tcam_action_ram #(.ENTRIES(ENTRIES), .ACT_W(ACT_W)) u_act (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_action),
    .re(srch_en), .raddr(win_idx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= srch_en;
      if (srch_en) begin
        res_hit <= any;
        res_idx <= any ? win_idx : '0;
      end
    end
  end

  assign res_action = res_hit ? ram_q : MISS_ACT;

  assert_result_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> res_valid);
  assert_no_spurious_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> !res_valid);
  assert_miss_default_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_action == MISS_ACT && res_idx == '0));
  assert_no_match_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (srch_en && match == '0) |=> !res_hit);
endmodule

// File: tb/tcam_classifier_test.sv
module tcam_classifier_test;
  localparam int N = 16;
  localparam int KW = 40;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic wr_valid = 1'b0;
  logic [KW-1:0] wr_value = '0, wr_mask = '0;
  logic [AW-1:0] wr_action = '0;
  logic srch_en = 1'b0;
  logic [KW-1:0] srch_key = '0;
  logic res_valid, res_hit;
  logic [3:0] res_idx;
  logic [AW-1:0] res_action;

  always #2 clk = ~clk;

  tcam_classifier uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_action(wr_action),
    .srch_en(srch_en), .srch_key(srch_key), .res_valid(res_valid),
    .res_hit(res_hit), .res_idx(res_idx), .res_action(res_action)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [KW-1:0] m_val [N];
  logic [KW-1:0] m_msk [N];
  logic [AW-1:0] m_act [N];
  bit            m_vld [N];

  logic [12:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [12:0] model(input logic [KW-1:0] key);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && (((key ^ m_val[i]) & m_msk[i]) == '0))
        return {1'b1, 4'(i), m_act[i]};
    return {1'b0, 4'd0, 8'hFF};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_cycle(input bit w, input int idx, input bit v,
                          input logic [KW-1:0] val, input logic [KW-1:0] msk,
                          input logic [AW-1:0] act, input bit s,
                          input logic [KW-1:0] key, input string tag);
    @(negedge clk);
    wr_en = w; wr_idx = 4'(idx); wr_valid = v; wr_value = val; wr_mask = msk;
    wr_action = act; srch_en = s; srch_key = key;
    if (s) begin
      exp_q.push_back(model(key));
      tag_q.push_back(tag);
    end
    if (w) begin
      m_vld[idx] = v; m_val[idx] = val; m_msk[idx] = msk; m_act[idx] = act;
    end
  endtask

  task automatic wr(input int idx, input bit v, input logic [KW-1:0] val,
                    input logic [KW-1:0] msk, input logic [AW-1:0] act);
    do_cycle(1, idx, v, val, msk, act, 0, '0, "");
  endtask

  task automatic srch(input logic [KW-1:0] key, input string tag);
    do_cycle(0, 0, 0, '0, '0, '0, 1, key, tag);
  endtask

  task automatic idle();
    do_cycle(0, 0, 0, '0, '0, '0, 0, '0, "");
  endtask

  // monitor: compare each result with the oldest expected item
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected result", 32'(res_valid), 32'd0);
      end else begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'({res_hit, res_idx, res_action}), 32'(e));
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_act[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset res_valid", 32'(res_valid), 32'd0);
    check("R7 reset res_hit", 32'(res_hit), 32'd0);
    srch(40'h0A000001_06, "R7 R6 empty table miss");

    // R2 exact rule at index 5
    wr(5, 1, 40'h0A000001_06, {KW{1'b1}}, 8'h55);
    srch(40'h0A000001_06, "R2 R5 exact hit");
    srch(40'h0A000001_07, "R3 one bit differs miss");
    srch(40'h8A000001_06, "R3 top bit differs miss");

    // R1 prefix rule at 3, protocol masked off
    wr(3, 1, 40'h0A000000_00, 40'hFF000000_00, 8'h33);
    srch(40'h0A7F1234_11, "R1 masked bits ignored");
    srch(40'h0A000001_06, "R4 lowest index wins");
    srch(40'h0B000001_06, "R2 cared bit mismatch miss");

    // protocol-only rule at 7
    wr(7, 1, 40'h00000000_11, 40'h00000000_FF, 8'h77);
    srch(40'h01020304_11, "R1 protocol only hit");
    srch(40'h01020304_12, "R6 protocol differs miss");

    // R10 longest prefix ordering
    wr(1, 1, 40'hC0A80100_00, 40'hFFFFFF00_00, 8'h11);
    wr(2, 1, 40'hC0A80000_00, 40'hFFFF0000_00, 8'h22);
    srch(40'hC0A80107_06, "R10 /24 chosen");
    srch(40'hC0A80207_06, "R10 /16 chosen");

    // R9 write and search in the same cycle
    do_cycle(1, 0, 1, '0, '0, 8'hA0, 1, 40'h0A7F1234_11, "R9 same-cycle search sees old table");
    srch(40'h0A7F1234_11, "R9 next search sees write");
    srch(40'h55555555_55, "R1 all wildcard hit");

    // R7 invalidate
    wr(0, 0, '0, '0, 8'hA0);
    srch(40'h0A7F1234_11, "R7 invalidated rule skipped");
    srch(40'h55555555_55, "R7 invalidated rule miss");
    wr(7, 0, 40'h00000000_11, 40'h00000000_FF, 8'h77);
    srch(40'h01020304_11, "R7 second invalidate miss");

    // R8 strobe drops when idle
    idle();
    @(negedge clk);
    check("R8 idle res_valid", 32'(res_valid), 32'd0);
    idle();
    check("R8 queue drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule